// File: doc/BRIEF.md
# Disciplined Nanosecond Clock with Staged Updates

This block keeps the time of a precision time protocol clock that runs from a 125 MHz reference. A 32-bit rate word is added every cycle to a 28-bit fraction register. The rate word's upper four bits, plus the carry out of the fraction, advance a 48-bit nanosecond count. Beside that count, a seconds/nanoseconds time code advances by the same step. Its nanoseconds field rolls over at one billion into a 48-bit seconds field.

Software never changes the running state directly. New count, time code and rate values go in 16 bits at a time through a plain write port into a bank of staging registers. They are committed together at the next rising edge of the frame-sync trigger. A staged field is committed only if its load-select bit allows it. The count and the time code also need the init mode to be on at that moment. The trigger comes either from a software control bit or from an external pin.

Top module: `nco_time_counter`

## Requirements
- R1: While reset is held, the count and both time code fields read 0 and the active rate word reads 0x8000_0000.
- R2: Each cycle the count advances by the rate word's bits [31:28] plus the carry from adding bits [27:0] into the 28-bit fraction. With the rate 0x8000_0000 it gains exactly 8 per cycle, and with 0x8800_0000 it gains 17 over any two cycles.
- R3: The staged rate is written as a low half (address 8) and a high half (address 9). It replaces the active rate only at a trigger event while load-select bit 6 (address 10) is set, and it is used from the following cycle.
- R4: The staged count is written at address 5 (bits [19:4]), address 6 (bits [35:20]) and the low 12 bits of address 7 (bits [47:36]). It is loaded with bits [3:0] at zero and the fraction cleared. This happens at an event only when load-select bit 7 is set and init (control bit 12, address 12) is on.
- R5: The staged time code is written as nanoseconds low and high at addresses 0 and 1, and as seconds at addresses 2, 3 and 4 from low to high. It is loaded at an event only when load-select bit 10 is set and init is on.
- R6: At an event with init off, the count and the time code keep running unchanged and the load selects stay set.
- R7: At an event with init on, all load selects clear, so a further event with no new select loads no rate.
- R8: The trigger is control bit 5 OR the fsync_in pin, with the pin registered for one cycle. Only a 0-to-1 transition is an event, so a trigger held high commits once.
- R9: Bit 6 of the permanent-enable register (address 11) lets the rate load at every event, with no select needed.
- R10: When the time code nanoseconds plus the step reach 1,000,000,000, the nanoseconds wrap to the remainder and the seconds increase by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| fsync_in | input | 1 | External frame-sync trigger |
| time_ns | output | 48 | Running nanosecond count |
| tc_sec | output | 48 | Time code seconds |
| tc_nsec | output | 32 | Time code nanoseconds |
| freq_active | output | 32 | Rate word in use |

## Verification
The rate is driven with the nominal word, which has no fraction and so separates the integer path from the carry path. It is then driven with a word holding half a nanosecond of fraction, where a dropped carry shows up as 16 instead of 17 over two cycles. Triggers are sent with and without init and with selects set, cleared and permanently enabled. This separates the gating terms from each other. The pin and the control bit are each held high across a changed staging value, which tells level sensing apart from edge sensing. A time code staged 20 ns below the second boundary shows the rollover into the seconds field.

// File: rtl/nco_tc_pkg.sv
package nco_tc_pkg;
  // staging register addresses
  localparam int ADR_TCNS0 = 0;
  localparam int ADR_TCNS1 = 1;
  localparam int ADR_SEC0  = 2;
  localparam int ADR_SEC1  = 3;
  localparam int ADR_SEC2  = 4;
  localparam int ADR_CNT0  = 5;
  localparam int ADR_CNT1  = 6;
  localparam int ADR_CNT2  = 7;
  localparam int ADR_FRQ0  = 8;
  localparam int ADR_FRQ1  = 9;
  localparam int N_STAGE   = 10;
  // control register addresses
  localparam int ADR_LDSEL = 10;
  localparam int ADR_LDPRM = 11;
  localparam int ADR_CTRL  = 12;
  // bit positions decoded from written words
  localparam int BIT_LD_TC  = 10;
  localparam int BIT_LD_CNT = 7;
  localparam int BIT_LD_FRQ = 6;
  localparam int BIT_INIT   = 12;
  localparam int BIT_SWTRIG = 5;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;
endpackage

// File: rtl/nco_stage_bank.sv
module nco_stage_bank
  import nco_tc_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 4,
  parameter int FREQ_W = 32,
  parameter logic [FREQ_W-1:0] NOM_FREQ = 32'h8000_0000
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [REG_W-1:0]                wr_data,
  input  logic                            sel_clr,
  output logic [N_STAGE-1:0][REG_W-1:0]   stage,
  output logic                            sel_tc,
  output logic                            sel_cnt,
  output logic                            sel_frq,
  output logic                            perm_frq,
  output logic                            init_mode,
  output logic                            sw_trig
);
  localparam logic [REG_W-1:0] FRQ_LO = NOM_FREQ[REG_W-1:0];
  localparam logic [REG_W-1:0] FRQ_HI = NOM_FREQ[2*REG_W-1:REG_W];

  for (genvar i = 0; i < N_STAGE; i++) begin : g_stage
    localparam logic [REG_W-1:0] RST_V =
      (i == ADR_FRQ0) ? FRQ_LO : ((i == ADR_FRQ1) ? FRQ_HI : '0);
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= RST_V;
      end else if (wr_en && wr_addr == ADDR_W'(i)) begin
        q <= wr_data;
      end
    end
    assign stage[i] = q;
  end

  wire wr_sel  = wr_en && (wr_addr == ADDR_W'(ADR_LDSEL));
  wire wr_perm = wr_en && (wr_addr == ADDR_W'(ADR_LDPRM));
  wire wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_tc  <= 1'b0;
      sel_cnt <= 1'b0;
      sel_frq <= 1'b0;
    end else if (wr_sel) begin
      sel_tc  <= wr_data[BIT_LD_TC];
      sel_cnt <= wr_data[BIT_LD_CNT];
      sel_frq <= wr_data[BIT_LD_FRQ];
    end else if (sel_clr) begin
      sel_tc  <= 1'b0;
      sel_cnt <= 1'b0;
      sel_frq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      perm_frq  <= 1'b0;
      init_mode <= 1'b0;
      sw_trig   <= 1'b0;
    end else begin
      if (wr_perm) perm_frq <= wr_data[BIT_LD_FRQ];
      if (wr_ctrl) begin
        init_mode <= wr_data[BIT_INIT];
        sw_trig   <= wr_data[BIT_SWTRIG];
      end
    end
  end
endmodule

// File: rtl/nco_fsync_edge.sv
module nco_fsync_edge (
  input  logic clk,
  input  logic rst,
  input  logic sw_trig,
  input  logic pin,
  output logic event_o
);
  logic pin_q;
  logic prev_q;
  logic trig;

  assign trig    = sw_trig | pin_q;
  assign event_o = trig & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pin_q  <= pin;
      prev_q <= trig;
    end
  end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int FREQ_W = 32,
  parameter int FRAC_W = 28,
  parameter int NS_W   = 48,
  parameter int NS_LSB = 4,
  parameter logic [FREQ_W-1:0] NOM_FREQ = 32'h8000_0000,
  localparam int INT_W  = FREQ_W - FRAC_W,
  localparam int STEP_W = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frq_ld,
  input  logic [FREQ_W-1:0] frq_stage,
  input  logic              cnt_ld,
  input  logic [NS_W-1:0]   cnt_stage,
  output logic [NS_W-1:0]   ns_q,
  output logic [FREQ_W-1:0] freq_q,
  output logic [STEP_W-1:0] step
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   fsum;

  assign fsum = {1'b0, frac_q} + {1'b0, freq_q[FRAC_W-1:0]};
  assign step = STEP_W'(freq_q[FREQ_W-1:FRAC_W]) + STEP_W'(fsum[FRAC_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (cnt_ld) begin
      ns_q   <= cnt_stage << NS_LSB;
      frac_q <= '0;
    end else begin
      ns_q   <= ns_q + NS_W'(step);
      frac_q <= fsum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= NOM_FREQ;
    end else if (frq_ld) begin
      freq_q <= frq_stage;
    end
  end
endmodule

// File: rtl/nco_timecode.sv
module nco_timecode
  import nco_tc_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int TCNS_W = 32,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [TCNS_W-1:0] ns_stage,
  input  logic [SEC_W-1:0]  sec_stage,
  input  logic [STEP_W-1:0] step,
  output logic [TCNS_W-1:0] ns_q,
  output logic [SEC_W-1:0]  sec_q
);
  localparam logic [TCNS_W:0] LIM = (TCNS_W+1)'(NS_PER_SEC);

  logic [TCNS_W:0] sum;
  logic            wrap;

  assign sum  = {1'b0, ns_q} + (TCNS_W+1)'(step);
  assign wrap = (sum >= LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else if (ld) begin
      ns_q  <= ns_stage;
      sec_q <= sec_stage;
    end else if (wrap) begin
      ns_q  <= TCNS_W'(sum - LIM);
      sec_q <= sec_q + SEC_W'(1);
    end else begin
      ns_q  <= TCNS_W'(sum);
    end
  end
endmodule

// File: rtl/nco_time_counter.sv
module nco_time_counter
  import nco_tc_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 4,
  parameter int FREQ_W = 32,
  parameter int FRAC_W = 28,
  parameter int NS_W   = 48,
  parameter int NS_LSB = 4,
  parameter int SEC_W  = 48,
  parameter int TCNS_W = 32,
  parameter logic [FREQ_W-1:0] NOM_FREQ = 32'h8000_0000,
  localparam int STEP_W = FREQ_W - FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              fsync_in,
  output logic [NS_W-1:0]   time_ns,
  output logic [SEC_W-1:0]  tc_sec,
  output logic [TCNS_W-1:0] tc_nsec,
  output logic [FREQ_W-1:0] freq_active
);
  logic [N_STAGE-1:0][REG_W-1:0] stage;
  logic sel_tc, sel_cnt, sel_frq, perm_frq, init_mode, sw_trig;
  logic fs_event, frq_ld, cnt_ld, tc_ld, sel_clr;
  logic [STEP_W-1:0] step;
  logic [FREQ_W-1:0] frq_stage;
  logic [NS_W-1:0]   cnt_stage;
  logic [TCNS_W-1:0] tcns_stage;
  logic [SEC_W-1:0]  sec_stage;

  assign frq_stage  = FREQ_W'({stage[ADR_FRQ1], stage[ADR_FRQ0]});
  assign cnt_stage  = NS_W'({stage[ADR_CNT2], stage[ADR_CNT1], stage[ADR_CNT0]});
  assign tcns_stage = TCNS_W'({stage[ADR_TCNS1], stage[ADR_TCNS0]});
  assign sec_stage  = SEC_W'({stage[ADR_SEC2], stage[ADR_SEC1], stage[ADR_SEC0]});

  // commit decisions at a trigger event
  assign frq_ld  = fs_event & (sel_frq | perm_frq);
  assign cnt_ld  = fs_event & init_mode & sel_cnt;
  assign tc_ld   = fs_event & init_mode & sel_tc;
  assign sel_clr = fs_event & init_mode;

  nco_stage_bank #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .FREQ_W(FREQ_W), .NOM_FREQ(NOM_FREQ)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_clr(sel_clr), .stage(stage), .sel_tc(sel_tc), .sel_cnt(sel_cnt),
    .sel_frq(sel_frq), .perm_frq(perm_frq), .init_mode(init_mode),
    .sw_trig(sw_trig)
  );

  nco_fsync_edge u_edge (
    .clk(clk), .rst(rst), .sw_trig(sw_trig), .pin(fsync_in), .event_o(fs_event)
  );

  nco_accum #(
    .FREQ_W(FREQ_W), .FRAC_W(FRAC_W), .NS_W(NS_W), .NS_LSB(NS_LSB),
    .NOM_FREQ(NOM_FREQ)
  ) u_accum (
    .clk(clk), .rst(rst), .frq_ld(frq_ld), .frq_stage(frq_stage),
    .cnt_ld(cnt_ld), .cnt_stage(cnt_stage), .ns_q(time_ns),
    .freq_q(freq_active), .step(step)
  );

  nco_timecode #(
    .SEC_W(SEC_W), .TCNS_W(TCNS_W), .STEP_W(STEP_W)
  ) u_tc (
    .clk(clk), .rst(rst), .ld(tc_ld), .ns_stage(tcns_stage),
    .sec_stage(sec_stage), .step(step), .ns_q(tc_nsec), .sec_q(tc_sec)
  );
endmodule

// File: rtl/nco_time_counter_chk.sv
module nco_time_counter_chk #(
  parameter int NS_W   = 48,
  parameter int TCNS_W = 32,
  parameter int FREQ_W = 32,
  parameter int FRAC_W = 28,
  parameter logic [FREQ_W-1:0] NOM_FREQ = 32'h8000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              fs_event,
  input logic              init_mode,
  input logic              sel_tc,
  input logic              sel_cnt,
  input logic              sel_frq,
  input logic              cnt_ld,
  input logic              tc_ld,
  input logic [NS_W-1:0]   time_ns,
  input logic [TCNS_W-1:0] tc_nsec,
  input logic [FREQ_W-1:0] freq_active
);
  localparam logic [TCNS_W-1:0] LIM = TCNS_W'(1_000_000_000);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (time_ns == '0 && tc_nsec == '0 && freq_active == NOM_FREQ));

  // R2
  ns_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cnt_ld)) |->
      ((time_ns - $past(time_ns)) == NS_W'($past(freq_active[FREQ_W-1:FRAC_W])) ||
       (time_ns - $past(time_ns)) == NS_W'($past(freq_active[FREQ_W-1:FRAC_W])) + NS_W'(1)));

  // R3
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fs_event)) |-> $stable(freq_active));

  // R6
  sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fs_event && !init_mode && !wr_en)) |->
      ({sel_tc, sel_cnt, sel_frq} == $past({sel_tc, sel_cnt, sel_frq})));

  // R7
  sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fs_event && init_mode && !wr_en)) |->
      ({sel_tc, sel_cnt, sel_frq} == 3'b000));

  // R8
  single_event_chk: assert property (@(posedge clk) disable iff (rst)
    fs_event |=> !fs_event);

  // R10
  tc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tc_ld) && $past(tc_nsec) < LIM) |-> (tc_nsec < LIM));
endmodule

bind nco_time_counter nco_time_counter_chk #(
  .NS_W(NS_W), .TCNS_W(TCNS_W), .FREQ_W(FREQ_W), .FRAC_W(FRAC_W),
  .NOM_FREQ(NOM_FREQ)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .fs_event(fs_event),
  .init_mode(init_mode), .sel_tc(sel_tc), .sel_cnt(sel_cnt), .sel_frq(sel_frq),
  .cnt_ld(cnt_ld), .tc_ld(tc_ld), .time_ns(time_ns), .tc_nsec(tc_nsec),
  .freq_active(freq_active)
);

// File: tb/test_nco_time_counter.sv
module test_nco_time_counter;
  localparam time CLK_PERIOD = 8ns;
  localparam int  WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        fsync_in = 1'b0;
  logic [47:0] time_ns;
  logic [47:0] tc_sec;
  logic [31:0] tc_nsec;
  logic [31:0] freq_active;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_time_counter i_nco_time_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsync_in(fsync_in), .time_ns(time_ns), .tc_sec(tc_sec), .tc_nsec(tc_nsec),
    .freq_active(freq_active)
  );

  // behavioural reference state
  logic [47:0] m_ns, m_tcsec, t_cnt;
  logic [27:0] m_frac;
  logic [31:0] m_freq, m_tcns;
  logic [15:0] m_sh [0:9];
  logic m_sel_tc, m_sel_cnt, m_sel_frq, m_perm, m_init, m_trig, m_fs, m_prev;
  logic t_trig, t_ev;
  logic [28:0] t_sum;
  logic [4:0]  t_step;
  logic [32:0] t_tc;

  always @(posedge clk) begin
    if (rst) begin
      m_ns = '0; m_frac = '0; m_freq = 32'h8000_0000; m_tcns = '0; m_tcsec = '0;
      for (int k = 0; k < 10; k++) m_sh[k] = 16'h0000;
      m_sh[9] = 16'h8000;
      m_sel_tc = 0; m_sel_cnt = 0; m_sel_frq = 0; m_perm = 0;
      m_init = 0; m_trig = 0; m_fs = 0; m_prev = 0;
    end else begin
      t_trig = m_trig | m_fs;
      t_ev   = t_trig & ~m_prev;
      t_sum  = {1'b0, m_frac} + {1'b0, m_freq[27:0]};
      t_step = {1'b0, m_freq[31:28]} + {4'b0, t_sum[28]};
      if (t_ev && m_init && m_sel_cnt) begin
        t_cnt = {m_sh[7], m_sh[6], m_sh[5]};
        m_ns = t_cnt << 4;
        m_frac = '0;
      end else begin
        m_ns = m_ns + 48'(t_step);
        m_frac = t_sum[27:0];
      end
      if (t_ev && m_init && m_sel_tc) begin
        m_tcns  = {m_sh[1], m_sh[0]};
        m_tcsec = {m_sh[4], m_sh[3], m_sh[2]};
      end else begin
        t_tc = {1'b0, m_tcns} + 33'(t_step);
        if (t_tc >= 33'd1_000_000_000) begin
          m_tcns  = 32'(t_tc - 33'd1_000_000_000);
          m_tcsec = m_tcsec + 48'd1;
        end else begin
          m_tcns = t_tc[31:0];
        end
      end
      if (t_ev && (m_sel_frq || m_perm)) m_freq = {m_sh[9], m_sh[8]};
      if (t_ev && m_init) begin m_sel_tc = 0; m_sel_cnt = 0; m_sel_frq = 0; end
      m_prev = t_trig;
      m_fs   = fsync_in;
      if (wr_en) begin
        if (wr_addr < 4'd10) m_sh[wr_addr] = wr_data;
        else if (wr_addr == 4'd10) begin
          m_sel_tc = wr_data[10]; m_sel_cnt = wr_data[7]; m_sel_frq = wr_data[6];
        end else if (wr_addr == 4'd11) m_perm = wr_data[6];
        else if (wr_addr == 4'd12) begin m_init = wr_data[12]; m_trig = wr_data[5]; end
      end
    end
  end

  task automatic report(input string tag, input bit ok,
                        input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      report("R2 R4 time_ns vs model", time_ns === m_ns, 64'(time_ns), 64'(m_ns));
      report("R5 R10 tc_nsec vs model", tc_nsec === m_tcns, 64'(tc_nsec), 64'(m_tcns));
      report("R5 R10 tc_sec vs model", tc_sec === m_tcsec, 64'(tc_sec), 64'(m_tcsec));
      report("R3 R9 freq vs model", freq_active === m_freq, 64'(freq_active), 64'(m_freq));
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_LIMIT && !done) begin
      fails++;
      $display("FAIL R1-watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit with_init);
    wr(4'd12, with_init ? 16'h1020 : 16'h0020);
    wr(4'd12, 16'h0000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [47:0] snap;

  initial begin
    idle(3);
    // R1 reset state
    report("R1 time_ns in reset", time_ns == 48'd0, 64'(time_ns), 64'd0);
    report("R1 tc_nsec in reset", tc_nsec == 32'd0, 64'(tc_nsec), 64'd0);
    report("R1 tc_sec in reset", tc_sec == 48'd0, 64'(tc_sec), 64'd0);
    report("R1 freq in reset", freq_active == 32'h8000_0000, 64'(freq_active), 64'h8000_0000);
    rst = 1'b0;
    idle(4);
    // R2 nominal step
    snap = time_ns; idle(5);
    report("R2 nominal 5 cycles", time_ns == snap + 48'd40, 64'(time_ns), 64'(snap + 48'd40));

    // R3 staged rate has no effect before an event
    wr(4'd8, 16'h0000); wr(4'd9, 16'h8800); idle(3);
    report("R3 rate held before event", freq_active == 32'h8000_0000, 64'(freq_active), 64'h8000_0000);
    wr(4'd10, 16'h0040); pulse(1'b0);
    report("R3 rate committed", freq_active == 32'h8800_0000, 64'(freq_active), 64'h8800_0000);
    snap = time_ns; idle(2);
    report("R2 R3 fractional two cycles", time_ns == snap + 48'd17, 64'(time_ns), 64'(snap + 48'd17));

    // R6 no init: count and time code keep running, selects kept
    wr(4'd5, 16'h1234); wr(4'd6, 16'hABCD); wr(4'd7, 16'hFFE1);
    wr(4'd10, 16'h0480); pulse(1'b0);
    report("R6 count not loaded without init", time_ns != 48'hFE1_ABCD_1234_0,
           64'(time_ns), 64'hFE1ABCD12340);
    // R4 with init, using the selects kept from before
    pulse(1'b1);
    report("R4 R6 count loaded", time_ns == 48'hFE1_ABCD_1234_0, 64'(time_ns), 64'hFE1ABCD12340);
    report("R5 tc loaded zero", tc_nsec == 32'd0, 64'(tc_nsec), 64'd0);
    idle(1);
    report("R4 fraction cleared", time_ns == 48'hFE1_ABCD_1234_8, 64'(time_ns), 64'hFE1ABCD12348);

    // R7 selects cleared by the init event
    wr(4'd9, 16'h8000); pulse(1'b1);
    report("R7 no rate load after clear", freq_active == 32'h8800_0000, 64'(freq_active), 64'h8800_0000);

    // R9 permanent enable
    wr(4'd11, 16'h0040); pulse(1'b0);
    report("R9 permanent load", freq_active == 32'h8000_0000, 64'(freq_active), 64'h8000_0000);
    wr(4'd9, 16'h9000); pulse(1'b0);
    report("R9 second event loads", freq_active == 32'h9000_0000, 64'(freq_active), 64'h9000_0000);

    // R8 pin trigger, held level
    wr(4'd9, 16'h8400);
    fsync_in = 1'b1; idle(2);
    report("R8 pin edge loads", freq_active == 32'h8400_0000, 64'(freq_active), 64'h8400_0000);
    wr(4'd9, 16'h8000); idle(5);
    report("R8 held pin no reload", freq_active == 32'h8400_0000, 64'(freq_active), 64'h8400_0000);
    fsync_in = 1'b0; idle(2);
    fsync_in = 1'b1; idle(2);
    report("R8 new pin edge loads", freq_active == 32'h8000_0000, 64'(freq_active), 64'h8000_0000);
    fsync_in = 1'b0;
    // R8 software bit held high
    wr(4'd12, 16'h0020); wr(4'd9, 16'h8800); idle(4);
    report("R8 held control bit", freq_active == 32'h8000_0000, 64'(freq_active), 64'h8000_0000);
    wr(4'd12, 16'h0000); pulse(1'b0);
    report("R8 control re-raised", freq_active == 32'h8800_0000, 64'(freq_active), 64'h8800_0000);
    wr(4'd9, 16'h8000); pulse(1'b0);

    // R5 and R10 time code load and rollover
    wr(4'd0, 16'hC9EC); wr(4'd1, 16'h3B9A);
    wr(4'd2, 16'h0005); wr(4'd3, 16'h0001); wr(4'd4, 16'h0000);
    wr(4'd10, 16'h0400); pulse(1'b1);
    report("R5 tc ns loaded", tc_nsec == 32'd999_999_980, 64'(tc_nsec), 64'd999999980);
    report("R5 tc sec loaded", tc_sec == 48'h1_0005, 64'(tc_sec), 64'h10005);
    idle(2);
    report("R10 below boundary", tc_nsec == 32'd999_999_996, 64'(tc_nsec), 64'd999999996);
    idle(1);
    report("R10 ns wrapped", tc_nsec == 32'd4, 64'(tc_nsec), 64'd4);
    report("R10 sec incremented", tc_sec == 48'h1_0006, 64'(tc_sec), 64'h10006);
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule